// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block receives configuration words for a two-channel frequency synthesizer over a three-wire serial link: a serial clock, a data line and a load strobe. All three inputs are brought into the system clock domain through synchronizer chains. A 23-bit shift register then takes one bit on each rising edge of the serial clock, most significant bit first. When the load strobe rises, the two bits shifted in last act as an address. They route the whole word into one of four configuration latches: the reference divider latch or the feedback divider latch, each for the low-band channel (0) or the high-band channel (1).

The two latch kinds decode the same 23 bits differently. A reference word carries a 14-bit reference ratio, a charge-pump current select and two monitor-select bits. A feedback word carries an 11-bit main count, a 7-bit swallow count, a prescaler select, a phase polarity bit and the monitor-enable bit. The latched fields are presented as outputs. A decoded monitor code tells the output stage whether the monitor pin shows the lock signal or one of four divider pulses.

Top module: `serial_cfg_loader`

## Requirements
- R1: After reset every reference ratio is 3, every main count is 3, every swallow count is 0, all single-bit fields are 0, and the monitor code is 0 (lock signal).
- R2: Word bit k (k = 1..23) is the bit shifted in (24-k)th, so the bit sent first is bit 23. Exactly one bit is taken per rising serial clock edge.
- R3: On a load strobe rising edge, bit 1 (channel select, 1 = high band) and bit 2 (kind select, 1 = feedback) choose the latch: 00 low-band reference, 10 high-band reference, 01 low-band feedback, 11 high-band feedback (written as bit1,bit2). No other latch changes.
- R4: Reference word fields: bit 3 is monitor select T1, bit 4 is T2, bits 5..18 are the ratio with its LSB at bit 5, bit 19 is the current select, and bits 20..23 are ignored.
- R5: A reference word whose ratio is below 3 is discarded and the addressed latch keeps its value. A ratio of 3 is accepted.
- R6: Feedback word fields: bit 3 is monitor enable, bit 4 is prescaler select, bit 5 is phase polarity, bits 6..12 are the swallow count with its LSB at bit 6, and bits 13..23 are the main count with its LSB at bit 13.
- R7: The current select output of a channel is 1 (high current) exactly when the last accepted reference word for that channel had bit 19 set.
- R8: The monitor code is 0 (lock) while the low-band feedback latch holds monitor enable 0. Otherwise it is 1 + T1 + 2*T2, taken from the low-band reference latch: 1 low-band reference pulse, 2 high-band reference pulse, 3 low-band feedback pulse, 4 high-band feedback pulse.
- R9: Serial clock edges that occur while the load strobe is high do not shift the register.
- R10: When more than 23 bits are shifted before a load, only the last 23 bits form the word.
- R11: A latch holds its contents until a later load addresses it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Serial shift clock, asynchronous |
| serData | input | 1 | Serial data, MSB first |
| serLe | input | 1 | Load strobe; rising edge transfers the word |
| refRatio | output | 2x14 | Reference ratio per channel |
| chgPumpHi | output | 2 | High charge-pump current select per channel |
| monT1 | output | 2 | Monitor select T1 per channel |
| monT2 | output | 2 | Monitor select T2 per channel |
| fbSwallow | output | 2x7 | Swallow count per channel |
| fbCount | output | 2x11 | Main feedback count per channel |
| preSel | output | 2 | Prescaler select per channel |
| phasePol | output | 2 | Phase polarity per channel |
| monLds | output | 2 | Monitor enable per channel |
| monSel | output | 3 | Decoded monitor code |

## Verification
The hardest case to reach is a serial clock edge that arrives while the load strobe is already high. Its effect can only be seen by a later reload. The stimulus therefore loads a known word and raises the strobe, then toggles the serial clock with ones on the data line. It drops and raises the strobe again without any shifting in between. The original latch must keep its contents, and the high-band feedback latch, which a corrupted address would hit, must stay at its default. An overlong burst of leading bits, ratios just below the floor, and the full sweep of monitor combinations across two latches cover the remaining corners.

// File: rtl/serial_cfg_pkg.sv
package serial_cfg_pkg;

  typedef struct packed {
    logic shiftEn;
    logic loadEn;
    logic bitIn;
  } strobe_t;

  typedef enum logic [2:0] {
    MON_LOCK   = 3'd0,
    MON_LO_REF = 3'd1,
    MON_HI_REF = 3'd2,
    MON_LO_FB  = 3'd3,
    MON_HI_FB  = 3'd4
  } monSel_e;

endpackage

// File: rtl/serial_cfg_ctrl.sv
module serial_cfg_ctrl
  import serial_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    serClk,
  input  logic    serData,
  input  logic    serLe,
  output strobe_t strobes
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] clkSync;
  logic [TOP:0] dataSync;
  logic [TOP:0] leSync;
  logic         clkLast;
  logic         leLast;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (!rstN) begin
          clkSync  <= '0;
          dataSync <= '0;
          leSync   <= '0;
        end else begin
          clkSync  <= serClk;
          dataSync <= serData;
          leSync   <= serLe;
        end
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (!rstN) begin
          clkSync  <= '0;
          dataSync <= '0;
          leSync   <= '0;
        end else begin
          clkSync  <= {clkSync[TOP-1:0], serClk};
          dataSync <= {dataSync[TOP-1:0], serData};
          leSync   <= {leSync[TOP-1:0], serLe};
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkLast <= 1'b0;
      leLast  <= 1'b0;
    end else begin
      clkLast <= clkSync[TOP];
      leLast  <= leSync[TOP];
    end
  end

  logic clkRise;
  logic leRise;

  always_comb begin
    clkRise         = clkSync[TOP] & ~clkLast;
    leRise          = leSync[TOP] & ~leLast;
    strobes.shiftEn = clkRise & ~leSync[TOP];
    strobes.loadEn  = leRise;
    strobes.bitIn   = dataSync[TOP];
  end

  AST_NO_SHIFT_AT_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadEn |-> !strobes.shiftEn) else $error("shift during load"); // R9

  AST_LOAD_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadEn |=> !strobes.loadEn) else $error("load strobe repeated"); // R3

endmodule

// File: rtl/serial_cfg_datapath.sv
module serial_cfg_datapath
  import serial_cfg_pkg::*;
#(
  parameter int R_W       = 14,
  parameter int A_W       = 7,
  parameter int N_W       = 11,
  parameter int RATIO_MIN = 3,
  parameter int NUM_CH    = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strobes,
  output logic [NUM_CH-1:0][R_W-1:0]  refRatio,
  output logic [NUM_CH-1:0]           chgPumpHi,
  output logic [NUM_CH-1:0]           monT1,
  output logic [NUM_CH-1:0]           monT2,
  output logic [NUM_CH-1:0][A_W-1:0]  fbSwallow,
  output logic [NUM_CH-1:0][N_W-1:0]  fbCount,
  output logic [NUM_CH-1:0]           preSel,
  output logic [NUM_CH-1:0]           phasePol,
  output logic [NUM_CH-1:0]           monLds,
  output logic [2:0]                  monSel
);

  // Field positions (zero-based index = word bit number - 1)
  localparam int WORD_W  = 5 + A_W + N_W;
  localparam int CN1_POS = 0;
  localparam int CN2_POS = 1;
  localparam int T1_POS  = 2;
  localparam int T2_POS  = 3;
  localparam int R_LO    = 4;
  localparam int R_HI    = R_LO + R_W - 1;
  localparam int CS_POS  = R_HI + 1;
  localparam int LDS_POS = 2;
  localparam int SW_POS  = 3;
  localparam int FC_POS  = 4;
  localparam int A_LO    = 5;
  localparam int A_HI    = A_LO + A_W - 1;
  localparam int N_LO    = A_HI + 1;
  localparam int N_HI    = N_LO + N_W - 1;

  logic [WORD_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) shiftReg <= '0;
    else if (strobes.shiftEn) shiftReg <= {shiftReg[WORD_W-2:0], strobes.bitIn};
  end

  logic           chanSel;
  logic           kindFb;
  logic [R_W-1:0] ratioField;
  logic           ratioOk;

  always_comb begin
    chanSel    = shiftReg[CN1_POS];
    kindFb     = shiftReg[CN2_POS];
    ratioField = shiftReg[R_HI:R_LO];
    ratioOk    = (32'(ratioField) >= RATIO_MIN);
  end

  logic [NUM_CH-1:0] refWr;
  logic [NUM_CH-1:0] fbWr;

  generate
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      assign refWr[ch] = strobes.loadEn & ~kindFb & (chanSel == 1'(ch)) & ratioOk;
      assign fbWr[ch]  = strobes.loadEn &  kindFb & (chanSel == 1'(ch));

      always_ff @(posedge clk) begin
        if (!rstN) begin
          refRatio[ch]  <= R_W'(RATIO_MIN);
          chgPumpHi[ch] <= 1'b0;
          monT1[ch]     <= 1'b0;
          monT2[ch]     <= 1'b0;
        end else if (refWr[ch]) begin
          refRatio[ch]  <= ratioField;
          chgPumpHi[ch] <= shiftReg[CS_POS];
          monT1[ch]     <= shiftReg[T1_POS];
          monT2[ch]     <= shiftReg[T2_POS];
        end
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          fbSwallow[ch] <= '0;
          fbCount[ch]   <= N_W'(RATIO_MIN);
          preSel[ch]    <= 1'b0;
          phasePol[ch]  <= 1'b0;
          monLds[ch]    <= 1'b0;
        end else if (fbWr[ch]) begin
          fbSwallow[ch] <= shiftReg[A_HI:A_LO];
          fbCount[ch]   <= shiftReg[N_HI:N_LO];
          preSel[ch]    <= shiftReg[SW_POS];
          phasePol[ch]  <= shiftReg[FC_POS];
          monLds[ch]    <= shiftReg[LDS_POS];
        end
      end

      AST_REF_FLOOR: assert property (@(posedge clk) disable iff (!rstN)
        32'(refRatio[ch]) >= RATIO_MIN) else $error("ratio below floor"); // R5

      AST_REF_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        !refWr[ch] |=> $stable(refRatio[ch])) else $error("ref latch moved"); // R11

      AST_FB_HOLD: assert property (@(posedge clk) disable iff (!rstN)
        !fbWr[ch] |=> $stable(fbCount[ch])) else $error("fb latch moved"); // R11

      AST_REF_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
        refWr[ch] |=> refRatio[ch] == $past(shiftReg[R_HI:R_LO])) else $error("ref capture"); // R4

      AST_FB_CAPTURE: assert property (@(posedge clk) disable iff (!rstN)
        fbWr[ch] |=> fbCount[ch] == $past(shiftReg[N_HI:N_LO])) else $error("fb capture"); // R6
    end
  endgenerate

  monSel_e monCode;

  always_comb begin
    if (!monLds[0]) monCode = MON_LOCK;
    else begin
      unique case ({monT2[0], monT1[0]})
        2'b00:   monCode = MON_LO_REF;
        2'b01:   monCode = MON_HI_REF;
        2'b10:   monCode = MON_LO_FB;
        default: monCode = MON_HI_FB;
      endcase
    end
  end

  assign monSel = monCode;

  AST_ONE_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({refWr, fbWr})) else $error("multiple latches written"); // R3

  AST_MON_LOCK: assert property (@(posedge clk) disable iff (!rstN)
    !monLds[0] |-> monSel == 3'd0) else $error("monitor not lock"); // R8

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
  import serial_cfg_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int R_W         = 14,
  parameter int A_W         = 7,
  parameter int N_W         = 11,
  parameter int RATIO_MIN   = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serClk,
  input  logic             serData,
  input  logic             serLe,
  output logic [1:0][R_W-1:0] refRatio,
  output logic [1:0]       chgPumpHi,
  output logic [1:0]       monT1,
  output logic [1:0]       monT2,
  output logic [1:0][A_W-1:0] fbSwallow,
  output logic [1:0][N_W-1:0] fbCount,
  output logic [1:0]       preSel,
  output logic [1:0]       phasePol,
  output logic [1:0]       monLds,
  output logic [2:0]       monSel
);

  localparam int NUM_CH = 2;

  strobe_t strobes;

  serial_cfg_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrl_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serLe(serLe), .strobes(strobes)
  );

  serial_cfg_datapath #(
    .R_W(R_W), .A_W(A_W), .N_W(N_W), .RATIO_MIN(RATIO_MIN), .NUM_CH(NUM_CH)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .refRatio(refRatio), .chgPumpHi(chgPumpHi), .monT1(monT1), .monT2(monT2),
    .fbSwallow(fbSwallow), .fbCount(fbCount), .preSel(preSel),
    .phasePol(phasePol), .monLds(monLds), .monSel(monSel)
  );

endmodule

// File: tb/serial_cfg_loader_tb_top.sv
`timescale 1ns/1ps
module serial_cfg_loader_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic serLe = 1'b0;
  logic [1:0][13:0] refRatio;
  logic [1:0] chgPumpHi, monT1, monT2, preSel, phasePol, monLds;
  logic [1:0][6:0] fbSwallow;
  logic [1:0][10:0] fbCount;
  logic [2:0] monSel;

  int testsRun = 0;
  int testsFailed = 0;

  always #10 clk = ~clk;

  serial_cfg_loader dut_i (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData), .serLe(serLe),
    .refRatio(refRatio), .chgPumpHi(chgPumpHi), .monT1(monT1), .monT2(monT2),
    .fbSwallow(fbSwallow), .fbCount(fbCount), .preSel(preSel),
    .phasePol(phasePol), .monLds(monLds), .monSel(monSel)
  );

  task automatic chk(input string req, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitClk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic shiftBit(input logic b);
    serData = b;
    waitClk(3);
    serClk = 1'b1;
    waitClk(3);
    serClk = 1'b0;
  endtask

  task automatic shiftWord(input logic [22:0] w);
    for (int k = 22; k >= 0; k--) shiftBit(w[k]);
  endtask

  task automatic pulseLe();
    waitClk(3);
    serLe = 1'b1;
    waitClk(6);
    serLe = 1'b0;
    waitClk(6);
  endtask

  task automatic sendWord(input logic [22:0] w);
    shiftWord(w);
    pulseLe();
  endtask

  function automatic logic [22:0] mkRef(input logic ch, input logic t1, input logic t2,
                                        input logic [13:0] r, input logic cs,
                                        input logic [3:0] dc);
    mkRef = {dc, cs, r, t2, t1, 1'b0, ch};
  endfunction

  function automatic logic [22:0] mkFb(input logic ch, input logic lds, input logic sw,
                                       input logic fc, input logic [6:0] a,
                                       input logic [10:0] n);
    mkFb = {n, a, fc, sw, lds, 1'b1, ch};
  endfunction

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin : stim
    int rVals[5];
    int aVals[3];
    int nVals[3];
    rVals = '{3, 4, 16383, 10922, 5461};
    aVals = '{0, 127, 85};
    nVals = '{3, 2047, 682};

    waitClk(4);
    rstN = 1'b1;
    waitClk(2);

    // R1 reset state
    for (int ch = 0; ch < 2; ch++) begin
      chk("R1 refRatio", int'(refRatio[ch]), 3);
      chk("R1 fbCount", int'(fbCount[ch]), 3);
      chk("R1 fbSwallow", int'(fbSwallow[ch]), 0);
      chk("R1 flags", int'({chgPumpHi[ch], monT1[ch], monT2[ch], preSel[ch], phasePol[ch], monLds[ch]}), 0);
    end
    chk("R1 monSel", int'(monSel), 0);

    // R2 R3 R4 R7 reference sweep per channel; other channel must not change
    for (int ch = 0; ch < 2; ch++) begin
      for (int i = 0; i < 5; i++) begin
        logic cs;
        logic t1;
        logic t2;
        int otherR;
        cs = i[0];
        t1 = i[1];
        t2 = i[0] ^ i[2];
        otherR = int'(refRatio[1-ch]);
        sendWord(mkRef(ch[0], t1, t2, 14'(rVals[i]), cs, 4'(i * 5)));
        chk("R4 ratio", int'(refRatio[ch]), rVals[i]);
        chk("R7 current select", int'(chgPumpHi[ch]), int'(cs));
        chk("R4 monitor T1", int'(monT1[ch]), int'(t1));
        chk("R4 monitor T2", int'(monT2[ch]), int'(t2));
        chk("R3 other ref untouched", int'(refRatio[1-ch]), otherR);
        chk("R3 fb untouched", int'(fbCount[ch]), 3);
      end
    end

    // R2 R3 R6 feedback sweep per channel
    for (int ch = 0; ch < 2; ch++) begin
      for (int i = 0; i < 3; i++) begin
        logic lds;
        logic sw;
        logic fc;
        int refKeep;
        lds = i[0];
        sw  = ~i[0];
        fc  = i[1];
        refKeep = int'(refRatio[ch]);
        sendWord(mkFb(ch[0], lds, sw, fc, 7'(aVals[i]), 11'(nVals[i])));
        chk("R6 main count", int'(fbCount[ch]), nVals[i]);
        chk("R6 swallow", int'(fbSwallow[ch]), aVals[i]);
        chk("R6 prescaler", int'(preSel[ch]), int'(sw));
        chk("R6 polarity", int'(phasePol[ch]), int'(fc));
        chk("R6 monitor enable", int'(monLds[ch]), int'(lds));
        chk("R11 ref holds", int'(refRatio[ch]), refKeep);
      end
    end

    // R5 floor: below 3 discarded, 3 accepted
    sendWord(mkRef(1'b0, 1'b0, 1'b0, 14'd700, 1'b1, 4'h0));
    for (int r = 0; r < 3; r++) begin
      sendWord(mkRef(1'b0, 1'b1, 1'b1, 14'(r), 1'b0, 4'hF));
      chk("R5 low ratio rejected", int'(refRatio[0]), 700);
      chk("R5 cs unchanged", int'(chgPumpHi[0]), 1);
    end
    sendWord(mkRef(1'b0, 1'b0, 1'b0, 14'd3, 1'b0, 4'h0));
    chk("R5 ratio 3 accepted", int'(refRatio[0]), 3);

    // R8 monitor decode: exhaustive over lds, T1, T2
    for (int lds = 0; lds < 2; lds++) begin
      for (int t = 0; t < 4; t++) begin
        sendWord(mkRef(1'b0, t[0], t[1], 14'd5, 1'b0, 4'h0));
        sendWord(mkFb(1'b0, lds[0], 1'b0, 1'b0, 7'd1, 11'd9));
        chk("R8 monitor code", int'(monSel), (lds == 0) ? 0 : 1 + t[0] + 2 * t[1]);
      end
    end

    // R9 serial edges with load strobe high are ignored
    sendWord(mkRef(1'b0, 1'b0, 1'b0, 14'd100, 1'b0, 4'h0));
    begin
      int fbHiKeep;
      fbHiKeep = int'(fbCount[1]);
      waitClk(3);
      serLe = 1'b1;
      waitClk(6);
      for (int i = 0; i < 6; i++) shiftBit(1'b1);
      waitClk(3);
      serLe = 1'b0;
      waitClk(6);
      pulseLe();
      chk("R9 ref kept after reload", int'(refRatio[0]), 100);
      chk("R9 high fb untouched", int'(fbCount[1]), fbHiKeep);
    end

    // R10 leading surplus bits dropped
    for (int i = 0; i < 5; i++) shiftBit(1'b1);
    sendWord(mkRef(1'b1, 1'b0, 1'b0, 14'd1234, 1'b0, 4'h0));
    chk("R10 surplus bits dropped", int'(refRatio[1]), 1234);
    chk("R10 cs from word", int'(chgPumpHi[1]), 0);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule